// File: doc/BRIEF.md
# Serial Configuration Register Port

This block lets a host load an operating setup into a data converter over a three-wire write-only link: an active-low port enable, a configuration clock and a configuration data line. All three lines are brought into the system clock domain. The block shifts bits into a holding register while the port is enabled. When the enable is released and the frame had exactly the right length, the holding register moves into an applied register. The decoded fields are presented as the device's configuration.

A hardware/software select picks the source of the configuration. When it is high, the outputs come straight from dedicated configuration pins and the applied register has no effect on them. When it is low, the applied register drives the outputs. A shared clock-invert input picks which edge of the configuration clock captures data.

Top module: `serial_cfg_port`

## Requirements
- R1: A frame is 12 bits sent most significant bit first. Bits [11:10] are the span code, bit [9] is the coding select (1 = twos complement), bit [8] is power-down (1 = powered down), and bits [7:0] have no effect on any output.
- R2: Configuration clock edges that occur while `cfg_en_n` is high shift nothing into the register and do not change the outputs.
- R3: With `clk_inv` low, data is captured on rising edges of `cfg_clk`.
- R4: With `clk_inv` high, data is captured on falling edges of `cfg_clk`.
- R5: With `hw_sel` high, the outputs follow `pin_span`, `pin_twos` and `pin_pdn`. The register contents are ignored, although a frame written in this mode is still stored.
- R6: With `hw_sel` low, the outputs show the last committed register value, and changes on the configuration pins have no effect.
- R7: A synchronous active-high `rst` clears the applied register, so in software mode all outputs read zero.
- R8: The register is committed only when `cfg_en_n` rises after exactly 12 captured bits. A frame of any other length leaves the applied configuration unchanged.
- R9: Span codes are decoded as 00 = 0 to 5, 01 = 0 to 10, 10 = ±5 and 11 = ±10. `out_bipolar` is code bit 1, and `out_wide` (doubled span) is code bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_sel | input | 1 | 1 = configuration from pins, 0 = from register |
| pin_span | input | 2 | Span code from dedicated pins |
| pin_twos | input | 1 | Coding select from dedicated pin |
| pin_pdn | input | 1 | Power-down from dedicated pin |
| clk_inv | input | 1 | 0 = rising capture edge, 1 = falling capture edge |
| cfg_en_n | input | 1 | Active-low port enable |
| cfg_clk | input | 1 | Configuration clock (asynchronous) |
| cfg_din | input | 1 | Configuration data (asynchronous) |
| out_span | output | 2 | Applied span code |
| out_bipolar | output | 1 | Applied span is bipolar |
| out_wide | output | 1 | Applied span is the doubled one |
| out_twos | output | 1 | Applied coding select |
| out_pdn | output | 1 | Applied power-down |

## Verification
The checks assume that each level of `cfg_clk` lasts at least three system clocks. They also assume that `cfg_din` changes at least one system clock before the capture edge, and that `cfg_en_n` moves only while `cfg_clk` is quiet, so that the synchronized copies stay in order. They further assume that `clk_inv`, `hw_sel` and the pins are quasi-static with respect to the serial stream. The stimulus holds every serial phase for four system clocks and drives all inputs on the falling system edge. It changes the data line between the two clock edges of each bit, so a capture on the wrong edge loads the complement of the intended word.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;

    localparam int CFG_W    = 12;
    localparam int SPAN_HI  = CFG_W - 1;
    localparam int SPAN_LO  = CFG_W - 2;
    localparam int TWOS_BIT = CFG_W - 3;
    localparam int PDN_BIT  = CFG_W - 4;

    typedef enum logic [1:0] {
        SPAN_UNI_5  = 2'b00,
        SPAN_UNI_10 = 2'b01,
        SPAN_BI_5   = 2'b10,
        SPAN_BI_10  = 2'b11
    } span_e;

    typedef struct packed {
        span_e span;
        logic  twos;
        logic  pdn;
    } cfg_t;

    function automatic cfg_t unpack_cfg(input logic [CFG_W-1:0] word);
        cfg_t c;
        c.span = span_e'(word[SPAN_HI:SPAN_LO]);
        c.twos = word[TWOS_BIT];
        c.pdn  = word[PDN_BIT];
        return c;
    endfunction

endpackage

// File: rtl/serial_cfg_sync.sv
module serial_cfg_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= RST_VAL;
        else     stage_q[0] <= d_async;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_chain
        always_ff @(posedge clk) begin
            if (rst) stage_q[g] <= RST_VAL;
            else     stage_q[g] <= stage_q[g-1];
        end
    end

    assign d_sync = stage_q[STAGES-1];

endmodule

// File: rtl/serial_cfg_shift.sv
module serial_cfg_shift
    import serial_cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clk_inv,
    input  logic             sclk_s,
    input  logic             sdin_s,
    input  logic             en_n_s,
    output logic [CFG_W-1:0] applied_q
);

    localparam int CNT_W   = $clog2(CFG_W + 2);
    localparam int CNT_MAX = CFG_W + 1;

    logic             sclk_prev, en_prev;
    logic [CFG_W-1:0] shreg_q;
    logic [CNT_W-1:0] cnt_q;
    logic             rise, fall, capture, en_rise;

    always_comb begin
        rise    = sclk_s & ~sclk_prev;
        fall    = ~sclk_s & sclk_prev;
        capture = ~en_n_s & (clk_inv ? fall : rise);
        en_rise = en_n_s & ~en_prev;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev <= 1'b0;
            en_prev   <= 1'b1;
            shreg_q   <= '0;
            cnt_q     <= '0;
            applied_q <= '0;
        end else begin
            sclk_prev <= sclk_s;
            en_prev   <= en_n_s;
            if (capture) begin
                shreg_q <= {shreg_q[CFG_W-2:0], sdin_s};
                if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
            end else if (en_n_s) begin
                cnt_q <= '0;
            end
            if (en_rise && cnt_q == CNT_W'(CFG_W)) applied_q <= shreg_q;
        end
    end

    // R8
    commit_len_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(applied_q) |-> $past(en_rise && cnt_q == CNT_W'(CFG_W)));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en_n_s && $past(en_n_s)) |-> $stable(shreg_q));

    // R7
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (applied_q == '0));

    // R8
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(CNT_MAX));

endmodule

// File: rtl/serial_cfg_select.sv
module serial_cfg_select
    import serial_cfg_pkg::*;
(
    input  logic hw_sel,
    input  cfg_t pin_cfg,
    input  cfg_t reg_cfg,
    output cfg_t act_cfg
);

    always_comb begin
        act_cfg = hw_sel ? pin_cfg : reg_cfg;
    end

endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
    import serial_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hw_sel,
    input  logic [1:0] pin_span,
    input  logic       pin_twos,
    input  logic       pin_pdn,
    input  logic       clk_inv,
    input  logic       cfg_en_n,
    input  logic       cfg_clk,
    input  logic       cfg_din,
    output logic [1:0] out_span,
    output logic       out_bipolar,
    output logic       out_wide,
    output logic       out_twos,
    output logic       out_pdn
);

    logic [2:0]       raw_lines, sync_lines;
    logic [CFG_W-1:0] applied;
    cfg_t             pin_cfg, reg_cfg, act_cfg;

    assign raw_lines = {cfg_en_n, cfg_clk, cfg_din};

    serial_cfg_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .d_async(raw_lines),
        .d_sync (sync_lines)
    );

    serial_cfg_shift u_shift (
        .clk      (clk),
        .rst      (rst),
        .clk_inv  (clk_inv),
        .sclk_s   (sync_lines[1]),
        .sdin_s   (sync_lines[0]),
        .en_n_s   (sync_lines[2]),
        .applied_q(applied)
    );

    always_comb begin
        pin_cfg.span = span_e'(pin_span);
        pin_cfg.twos = pin_twos;
        pin_cfg.pdn  = pin_pdn;
        reg_cfg      = unpack_cfg(applied);
    end

    serial_cfg_select u_sel (
        .hw_sel (hw_sel),
        .pin_cfg(pin_cfg),
        .reg_cfg(reg_cfg),
        .act_cfg(act_cfg)
    );

    assign out_span    = act_cfg.span;
    assign out_bipolar = act_cfg.span[1];
    assign out_wide    = act_cfg.span[0];
    assign out_twos    = act_cfg.twos;
    assign out_pdn     = act_cfg.pdn;

    // R6
    sw_pins_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (!hw_sel && $past(!hw_sel) && $stable(applied)) |->
        ($stable(out_span) && $stable(out_twos) && $stable(out_pdn)));

    // R5
    hw_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (hw_sel && $past(hw_sel) && $stable(pin_span) && $stable(pin_twos) && $stable(pin_pdn))
        |-> ($stable(out_span) && $stable(out_twos) && $stable(out_pdn)));

    // R9
    bipolar_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (out_span == 2'b10 || out_span == 2'b11) |-> (out_bipolar && (out_wide == out_span[0])));

endmodule

// File: tb/test_serial_cfg_port.sv
module test_serial_cfg_port;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [1:0] span;
        logic       twos;
        logic       pdn;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hw_sel = 1'b0;
    logic [1:0] pin_span = 2'b11;
    logic       pin_twos = 1'b1;
    logic       pin_pdn = 1'b1;
    logic       clk_inv = 1'b0;
    logic       cfg_en_n = 1'b1;
    logic       cfg_clk = 1'b0;
    logic       cfg_din = 1'b0;
    logic [1:0] out_span;
    logic       out_bipolar, out_wide, out_twos, out_pdn;

    int   errors = 0;
    int   checks = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_cfg_port i_serial_cfg_port (
        .clk(clk), .rst(rst), .hw_sel(hw_sel),
        .pin_span(pin_span), .pin_twos(pin_twos), .pin_pdn(pin_pdn),
        .clk_inv(clk_inv), .cfg_en_n(cfg_en_n), .cfg_clk(cfg_clk), .cfg_din(cfg_din),
        .out_span(out_span), .out_bipolar(out_bipolar), .out_wide(out_wide),
        .out_twos(out_twos), .out_pdn(out_pdn)
    );

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver side: push an expectation, the monitor compares on the next falling edge
    task automatic expect_cfg(input logic [1:0] s, input logic t, input logic p, input string tag);
        exp_t e;
        e.span = s; e.twos = t; e.pdn = p; e.tag = tag;
        sb_q.push_back(e);
        wt(2);
    endtask

    // each bit: data b, rising edge, data ~b, falling edge
    task automatic send(input logic [15:0] bits, input int n, input logic enable);
        cfg_en_n = ~enable;
        wt(4);
        for (int i = n - 1; i >= 0; i--) begin
            cfg_din = bits[i];  wt(4);
            cfg_clk = 1'b1;     wt(4);
            cfg_din = ~bits[i]; wt(4);
            cfg_clk = 1'b0;     wt(4);
        end
        cfg_en_n = 1'b1;
        wt(8);
    endtask

    function automatic logic [15:0] frame(input logic [1:0] s, input logic t, input logic p,
                                          input logic [7:0] junk);
        return {4'b0, s, t, p, junk};
    endfunction

    // monitor
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (out_span !== e.span || out_twos !== e.twos || out_pdn !== e.pdn ||
                out_bipolar !== e.span[1] || out_wide !== e.span[0]) begin
                errors++;
                $display("FAIL %s: got span=%b bip=%b wide=%b twos=%b pdn=%b, expected span=%b bip=%b wide=%b twos=%b pdn=%b",
                         e.tag, out_span, out_bipolar, out_wide, out_twos, out_pdn,
                         e.span, e.span[1], e.span[0], e.twos, e.pdn);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        wt(6);
        rst = 1'b0;
        wt(2);
        // R7: reset state in software mode
        expect_cfg(2'b00, 1'b0, 1'b0, "R7 reset state");

        // R1 R3 R6: rising capture, MSB first, junk bits ignored
        send(frame(2'b10, 1'b1, 1'b0, 8'hA5), 12, 1'b1);
        expect_cfg(2'b10, 1'b1, 1'b0, "R1 R3 rising capture");

        // R6: pins ignored in software mode
        pin_span = 2'b01; pin_twos = 1'b0; pin_pdn = 1'b1;
        wt(4);
        expect_cfg(2'b10, 1'b1, 1'b0, "R6 pins ignored");

        // R4: falling capture loads complement of the driven bits
        clk_inv = 1'b1;
        wt(4);
        send(~frame(2'b01, 1'b0, 1'b1, 8'h3C), 12, 1'b1);
        expect_cfg(2'b01, 1'b0, 1'b1, "R4 falling capture");
        clk_inv = 1'b0;
        wt(4);

        // R8: short and long frames discarded
        send(frame(2'b11, 1'b1, 1'b1, 8'h00) >> 1, 11, 1'b1);
        expect_cfg(2'b01, 1'b0, 1'b1, "R8 eleven bits");
        send({frame(2'b11, 1'b1, 1'b0, 8'hFF), 1'b0}, 13, 1'b1);
        expect_cfg(2'b01, 1'b0, 1'b1, "R8 thirteen bits");
        send(16'h0, 0, 1'b1);
        expect_cfg(2'b01, 1'b0, 1'b1, "R8 empty frame");

        // R2: clocking with port disabled
        send(frame(2'b10, 1'b1, 1'b0, 8'h0F), 12, 1'b0);
        expect_cfg(2'b01, 1'b0, 1'b1, "R2 disabled clocks");
        // R2: disabled edges must not pollute a following frame
        send(frame(2'b00, 1'b1, 1'b1, 8'h00), 12, 1'b1);
        expect_cfg(2'b00, 1'b1, 1'b1, "R2 frame after disabled clocks");

        // R5: hardware mode follows pins, register ignored but stored
        hw_sel = 1'b1; pin_span = 2'b11; pin_twos = 1'b1; pin_pdn = 1'b0;
        wt(2);
        expect_cfg(2'b11, 1'b1, 1'b0, "R5 pins drive");
        send(frame(2'b10, 1'b0, 1'b0, 8'h81), 12, 1'b1);
        expect_cfg(2'b11, 1'b1, 1'b0, "R5 frame ignored");
        pin_span = 2'b00; pin_pdn = 1'b1;
        wt(2);
        expect_cfg(2'b00, 1'b1, 1'b1, "R5 pin change");
        hw_sel = 1'b0;
        wt(2);
        expect_cfg(2'b10, 1'b0, 1'b0, "R6 register after hw mode");

        // R9: every span code
        for (int k = 0; k < 4; k++) begin
            send(frame(2'(k), k[0], k[1], 8'h5A), 12, 1'b1);
            expect_cfg(2'(k), k[0], k[1], "R9 span decode");
        end

        // R7: reset after configuration
        rst = 1'b1;
        wt(3);
        rst = 1'b0;
        wt(2);
        expect_cfg(2'b00, 1'b0, 1'b0, "R7 reset clears");

        wt(4);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule